// File: doc/BRIEF.md
# Sparse Column Hit Address Scanner

This block reads out one column of pixels. Each pixel raises a one-cycle hit strobe when it fires, and the scanner latches it into a sticky flag. A readout request, typically a first-level trigger, moves every latched flag into a scan vector. The scanner then hands out the address of one hit pixel per accepted transfer. It starts at the top of the column and works down, and it skips pixels that hold no hit. Each flag clears as soon as its address is taken, so the next hit pixel is offered on the next cycle. A readout of k hits therefore takes k transfers, not one transfer per pixel.

Addresses leave on a valid/ready stream. `addr_valid_o` is high throughout a readout. While `addr_ready_i` is low, the offered address stays put and nothing clears. This back-pressure input acts as the read clock enable. Hits that arrive while a readout is running are kept for the next request. `busy_o` and the one-cycle `done_o` pulse tell the surrounding logic when the scan has ended.

Top module: `sparse_col_scanner`

## Requirements
- R1: After reset the scanner is idle, with `addr_valid_o`, `busy_o` and `done_o` low, and no flag is latched, so a first request finds an empty column.
- R2: A high bit i on `hit_i` for one cycle latches flag i, and the flag stays set until a readout takes it.
- R3: Index 0 is the top of the column and has the highest priority. The addresses of one readout come out in strictly ascending index order, and `addr_valid_o` is only high while `busy_o` is high.
- R4: Each latched hit is offered exactly once per readout. Its flag clears on the cycle in which `addr_valid_o` and `addr_ready_i` are both high.
- R5: While `addr_valid_o` is high and `addr_ready_i` is low, `addr_valid_o` stays high and `addr_o` holds its value.
- R6: `done_o` pulses high for one cycle, in the cycle after the last address is accepted. In that same cycle `busy_o` and `addr_valid_o` go low.
- R7: A request with no latched flag raises `done_o` in the cycle after `start_i` is sampled, and no address is offered.
- R8: Hits that arrive during a readout are not offered in that readout. The next request offers them.
- R9: `start_i` has no effect while `busy_o` is high.
- R10: With `addr_ready_i` held high, a readout of k hits shows exactly k cycles of `addr_valid_o`, and they are consecutive.
- R11: `addr_o` is ceil(log2(NPIX)) bits wide, and while it is valid it is always below NPIX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_i | input | NPIX | Per-pixel hit strobes; bit 0 is the top pixel |
| start_i | input | 1 | Readout request, acted on only when idle |
| addr_ready_i | input | 1 | Sink ready for the address stream (read enable) |
| addr_o | output | AW | Address of the hit pixel offered now |
| addr_valid_o | output | 1 | Address stream valid |
| busy_o | output | 1 | Readout in progress |
| done_o | output | 1 | One-cycle pulse when a readout ends |

## Verification
The main readout is tried with several hit patterns. A lone top pixel and a lone bottom pixel show that both ends of the priority chain are reached. A full column checks the one-address-per-cycle rate at its longest. Scattered and paired masks show that empty pixels are skipped and that the order stays ascending across gaps. Directed cases then cover an empty request, a stalled sink holding its address, a higher-priority hit injected mid-scan that must wait for the next request, and a request raised while busy that must be ignored.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_e;
endpackage

// File: rtl/flag_bank.sv
// Sticky per-pixel hit flags waiting for the next readout request.
module flag_bank #(
  parameter int NPIX = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIX-1:0] hit_i,
  input  logic            take_i,   // all waiting flags move to the scan
  output logic [NPIX-1:0] pend_o
);
  logic [NPIX-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      pend_q <= '0;
    else if (take_i) pend_q <= hit_i;          // new hits wait for the next request
    else             pend_q <= pend_q | hit_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/prio_pick.sv
// Picks the lowest set index (top of the column) of a vector.
module prio_pick #(
  parameter int NPIX = 32,
  parameter int AW   = 5
) (
  input  logic [NPIX-1:0] vec_i,
  output logic [NPIX-1:0] onehot_o,
  output logic [AW-1:0]   idx_o
);
  logic [NPIX:0] seen;

  assign seen[0] = 1'b0;
  for (genvar g = 0; g < NPIX; g++) begin : g_chain
    assign onehot_o[g] = vec_i[g] & ~seen[g];
    assign seen[g+1]   = seen[g] | vec_i[g];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NPIX; i++) begin
      if (onehot_o[i]) idx_o = idx_o | AW'(i);
    end
  end
endmodule

// File: rtl/scan_ctrl.sv
// Readout sequencer: owns the scan vector and the idle/scan state.
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int NPIX = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            ready_i,
  input  logic [NPIX-1:0] pend_i,
  input  logic [NPIX-1:0] pick_i,
  output logic            take_o,
  output logic [NPIX-1:0] scan_o,
  output logic            busy_o,
  output logic            done_o
);
  scan_state_e     state_q;
  logic [NPIX-1:0] scan_q;
  logic            done_q;
  logic            fire;
  logic [NPIX-1:0] scan_left;

  assign take_o    = (state_q == ST_IDLE) && start_i;
  assign fire      = (state_q == ST_SCAN) && ready_i;
  assign scan_left = scan_q & ~pick_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      scan_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (take_o) begin
        scan_q <= pend_i;
        if (pend_i == '0) done_q  <= 1'b1;
        else              state_q <= ST_SCAN;
      end else if (fire) begin
        scan_q <= scan_left;
        if (scan_left == '0) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  assign scan_o = scan_q;
  assign busy_o = (state_q == ST_SCAN);
  assign done_o = done_q;
endmodule

// File: rtl/sparse_col_scanner.sv
module sparse_col_scanner #(
  parameter int NPIX = 32,
  localparam int AW  = (NPIX > 1) ? $clog2(NPIX) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIX-1:0] hit_i,
  input  logic            start_i,
  input  logic            addr_ready_i,
  output logic [AW-1:0]   addr_o,
  output logic            addr_valid_o,
  output logic            busy_o,
  output logic            done_o
);
  logic [NPIX-1:0] pend;
  logic [NPIX-1:0] scan;
  logic [NPIX-1:0] pick;
  logic            take;
  logic            busy;

  flag_bank #(.NPIX(NPIX)) u_flags (
    .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .take_i(take), .pend_o(pend)
  );

  prio_pick #(.NPIX(NPIX), .AW(AW)) u_pick (
    .vec_i(scan), .onehot_o(pick), .idx_o(addr_o)
  );

  scan_ctrl #(.NPIX(NPIX)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ready_i(addr_ready_i),
    .pend_i(pend), .pick_i(pick), .take_o(take), .scan_o(scan),
    .busy_o(busy), .done_o(done_o)
  );

  assign busy_o       = busy;
  assign addr_valid_o = busy;
endmodule

// File: rtl/sparse_col_scanner_chk.sv
module sparse_col_scanner_chk #(
  parameter int NPIX = 32,
  parameter int AW   = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr_ready_i,
  input logic [AW-1:0] addr_o,
  input logic          addr_valid_o,
  input logic          busy_o,
  input logic          done_o
);
  localparam logic [AW:0] LIMIT = (AW+1)'(NPIX);

  AST_VALID_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid_o |-> busy_o); // R3
  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid_o && addr_ready_i |=> !addr_valid_o || (addr_o > $past(addr_o))); // R3
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid_o && !addr_ready_i |=> addr_valid_o && $stable(addr_o)); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && !addr_valid_o); // R6
  AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o); // R6
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid_o |-> ({1'b0, addr_o} < LIMIT)); // R11
endmodule

bind sparse_col_scanner sparse_col_scanner_chk #(.NPIX(NPIX), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_ready_i(addr_ready_i), .addr_o(addr_o),
  .addr_valid_o(addr_valid_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/test_sparse_col_scanner.sv
module test_sparse_col_scanner;
  localparam int NP = 32;
  localparam int AWB = $clog2(NP);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NP-1:0]   hit_i = '0;
  logic            start_i = 1'b0;
  logic            addr_ready_i = 1'b1;
  logic [AWB-1:0]  addr_o;
  logic            addr_valid_o, busy_o, done_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  sparse_col_scanner #(.NPIX(NP)) i_sparse_col_scanner (
    .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .start_i(start_i),
    .addr_ready_i(addr_ready_i), .addr_o(addr_o), .addr_valid_o(addr_valid_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  localparam int NVEC = 6;
  localparam logic [NP-1:0] VEC [NVEC] = '{
    32'h0000_0001, 32'h8000_0000, 32'hFFFF_FFFF,
    32'hA5A5_0F0F, 32'h0001_8000, 32'h4000_0002
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load_and_start(input logic [NP-1:0] m);
    @(negedge clk); hit_i = m;
    @(negedge clk); hit_i = '0; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  // Samples from the current negedge onward until done, comparing the address
  // stream to the ascending set bits of expm.
  task automatic collect(input logic [NP-1:0] expm, input string tag,
                         input logic [NP-1:0] inject, input bit poke_start);
    int nxt = 0;
    int nvalid = 0;
    bit got_done = 0;
    for (int c = 0; c < NP + 4 && !got_done; c++) begin
      if (addr_valid_o) begin
        while (nxt < NP && !expm[nxt]) nxt++;
        check(int'(addr_o) == nxt, {tag, " R3 R4 address order"}, int'(addr_o), nxt);
        nxt++;
        nvalid++;
      end
      if (done_o) got_done = 1;
      if (c == 0) begin hit_i = inject; start_i = poke_start; end
      else begin hit_i = '0; start_i = 1'b0; end
      if (!got_done) @(negedge clk);
    end
    check(got_done, {tag, " R6 done seen"}, int'(got_done), 1);
    check(nvalid == $countones(expm), {tag, " R10 valid cycles"}, nvalid, $countones(expm));
    check(!busy_o && !addr_valid_o, {tag, " R6 idle at done"}, int'(busy_o), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!addr_valid_o && !busy_o && !done_o, "R1 outputs in reset", int'(busy_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!addr_valid_o && !busy_o && !done_o, "R1 outputs after reset", int'(addr_valid_o), 0);
    // R1/R7: empty request right after reset
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check(done_o && !addr_valid_o, "R1 R7 empty request done", int'(done_o), 1);
    @(negedge clk);
    check(!done_o, "R6 R7 done single pulse", int'(done_o), 0);

    // Vector table: R2 R3 R4 R10
    for (int v = 0; v < NVEC; v++) begin
      load_and_start(VEC[v]);
      collect(VEC[v], $sformatf("vec%0d", v), '0, 1'b0);
      @(negedge clk);
    end

    // R5: back-pressure holds the offered address
    addr_ready_i = 1'b0;
    load_and_start(32'h0000_0088);
    for (int s = 0; s < 3; s++) begin
      check(addr_valid_o && addr_o == 5'd3, "R5 stall holds address", int'(addr_o), 3);
      @(negedge clk);
    end
    addr_ready_i = 1'b1;
    collect(32'h0000_0088, "stall", '0, 1'b0);
    @(negedge clk);

    // R8: higher-priority hit during a scan waits for the next request
    load_and_start(32'h0000_0220);
    collect(32'h0000_0220, "R8 first", 32'h0000_0004, 1'b0);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    collect(32'h0000_0004, "R8 second", '0, 1'b0);
    @(negedge clk);

    // R9: start while busy is ignored; nothing is left afterwards
    load_and_start(32'h0010_1001);
    collect(32'h0010_1001, "R9 busy start", '0, 1'b1);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check(done_o && !addr_valid_o, "R9 R2 no leftover hits", int'(addr_valid_o), 0);
    @(negedge clk);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule